// File: doc/BRIEF.md
# Data-Space Access Unit with Byte and Bit Addressing

This block owns a small internal data space and serves one request at a time from an instruction-execution engine. The space has 256 bytes of general RAM (a lower and an upper half) and a 128-byte file of special-function registers. A request carries a mode, an 8-bit address, write data and a read/write flag. The block decodes the target, runs the memory cycles and signals completion with a one-cycle `done` pulse. Reads return the result on `rdata`.

There are three modes. A byte access in direct mode reaches lower RAM below address 0x80 and the register file from 0x80 up. A byte access in indirect mode reaches RAM across the whole 0x00–0xFF range, so the upper half of that range is RAM and never a register. A single-bit access maps a bit address to a containing byte and a bit position. A bit write is a read-modify-write on that byte, so it takes one extra memory cycle.

After reset the unit sweeps both memories once to load their start values, and it stays busy while it does so. Both memories are written as synchronous single-port arrays, so they can map onto block RAM.

Top module: `dmau_unit`

## Requirements
- R1: After reset the unit is busy during an initialisation sweep. When it finishes, every RAM byte reads 0x00 and every register-file byte reads 0x00, except 0x80, 0x90, 0xA0 and 0xB0, which read 0xFF, and 0x81, which reads 0x07.
- R2: A direct-mode access (mode code 0) with address below 0x80 reads or writes the lower RAM byte at that address.
- R3: A direct-mode access with address 0x80 or above reads or writes the register-file entry at address minus 0x80. Mode code 3 behaves exactly as direct mode.
- R4: An indirect-mode access (mode code 1) reads or writes the RAM byte at the full 8-bit address. At 0x80 and above it reaches upper RAM and never touches the register file.
- R5: In bit mode (mode code 2), a bit address below 0x80 selects RAM byte 0x20 plus (address >> 3), that is bytes 0x20–0x2F, at bit position address & 7.
- R6: In bit mode, a bit address of 0x80 or above selects the register-file byte at address & 0xF8, at bit position address & 7.
- R7: A bit write changes only the selected bit of the containing byte, setting it to bit 0 of the write data. Bits 7..1 of the write data have no effect.
- R8: A bit read returns 0x00 or 0x01 on rdata, equal to the selected bit.
- R9: A request is accepted on a clock edge where req_valid is high and busy is low. busy is high from the next cycle until done. done is a one-cycle pulse that rises 1 edge after acceptance for a byte write, 2 edges for a byte or bit read, and 3 edges for a bit write.
- R10: A request presented while busy is high is ignored and leaves memory unchanged.
- R11: rdata changes only when a read completes; writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 bit, 3 direct |
| req_addr | input | ADDR_W | Byte address or bit address |
| req_wdata | input | DATA_W | Write data (bit 0 only in bit mode) |
| req_write | input | 1 | 1 write, 0 read |
| busy | output | 1 | Request in progress or initialisation running |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Result of the last completed read |

## Verification
The bench sweeps every address in every mode against an arithmetic model of the two memories. Distinct value patterns are written through direct mode and through indirect mode in the upper half, then read back through both modes. Any confusion between upper RAM and the register file then shows up as a wrong value. Every one of the 256 bit addresses is set and cleared with junk in the upper write-data bits. After each step the bench reads the bit and the containing byte, which separates errors in byte selection, bit position and merge masking. Targeted cases check acceptance latency per operation type, a request dropped while busy, and rdata holding across writes.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

  localparam logic [1:0] MODE_DIRECT   = 2'd0;
  localparam logic [1:0] MODE_INDIRECT = 2'd1;
  localparam logic [1:0] MODE_BIT      = 2'd2;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_ISSUE,
    ST_FETCH,
    ST_WBACK
  } seq_state_e;

  // Start value of a register-file entry, by index inside the file.
  function automatic logic [7:0] sfr_start_value(input logic [15:0] idx);
    logic [7:0] v;
    case (idx)
      16'h0000, 16'h0010, 16'h0020, 16'h0030: v = 8'hFF;
      16'h0001:                               v = 8'h07;
      default:                                v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dmau_spram.sv
module dmau_spram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/dmau_decode.sv
module dmau_decode #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic [1:0]                      mode,
  input  logic [ADDR_W-1:0]               addr,
  output logic                            sel_sfr,
  output logic [ADDR_W-1:0]               ram_idx,
  output logic [ADDR_W-2:0]               sfr_idx,
  output logic [$clog2(DATA_W)-1:0]       bitpos
);
  import dmau_pkg::*;

  localparam int BP_W = $clog2(DATA_W);

  logic [ADDR_W-2-BP_W:0] group;
  assign group  = addr[ADDR_W-2:BP_W];
  assign bitpos = addr[BP_W-1:0];

  always_comb begin
    sel_sfr = 1'b0;
    ram_idx = addr;
    sfr_idx = addr[ADDR_W-2:0];
    case (mode)
      MODE_INDIRECT: begin
        sel_sfr = 1'b0;
        ram_idx = addr;
      end
      MODE_BIT: begin
        if (addr[ADDR_W-1]) begin
          sel_sfr = 1'b1;
          sfr_idx = {group, {BP_W{1'b0}}};
        end else begin
          sel_sfr = 1'b0;
          ram_idx = BIT_BASE + ADDR_W'(group);
        end
      end
      default: begin
        sel_sfr = addr[ADDR_W-1];
      end
    endcase
  end
endmodule

// File: rtl/dmau_seq.sv
module dmau_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [1:0]                req_mode,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic                      req_write,
  input  logic                      dec_sel_sfr,
  input  logic [ADDR_W-1:0]         dec_ram_idx,
  input  logic [ADDR_W-2:0]         dec_sfr_idx,
  input  logic [$clog2(DATA_W)-1:0] dec_bitpos,
  input  logic [DATA_W-1:0]         ram_rd,
  input  logic [DATA_W-1:0]         sfr_rd,
  output logic                      ram_we,
  output logic [ADDR_W-1:0]         ram_addr,
  output logic [DATA_W-1:0]         ram_wd,
  output logic                      sfr_we,
  output logic [ADDR_W-2:0]         sfr_addr,
  output logic [DATA_W-1:0]         sfr_wd,
  output logic [1:0]                lat_mode,
  output logic [ADDR_W-1:0]         lat_addr,
  output logic                      lat_write,
  output logic                      init_active,
  output logic                      busy,
  output logic                      done,
  output logic [DATA_W-1:0]         rdata
);
  import dmau_pkg::*;

  seq_state_e        state;
  logic [ADDR_W-1:0] init_cnt;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] merge_q;
  logic [DATA_W-1:0] fetched;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] pos_mask;
  logic              is_bit;

  assign is_bit      = (lat_mode == MODE_BIT);
  assign init_active = (state == ST_INIT);
  assign busy        = (state != ST_IDLE);
  assign fetched     = dec_sel_sfr ? sfr_rd : ram_rd;
  assign pos_mask    = DATA_W'(1) << dec_bitpos;
  assign merged      = (fetched & ~pos_mask) | (wdata_q[0] ? pos_mask : '0);

  // Memory port steering
  always_comb begin
    ram_we   = 1'b0;
    sfr_we   = 1'b0;
    ram_addr = dec_ram_idx;
    sfr_addr = dec_sfr_idx;
    ram_wd   = wdata_q;
    sfr_wd   = wdata_q;
    case (state)
      ST_INIT: begin
        ram_we   = 1'b1;
        ram_addr = init_cnt;
        ram_wd   = '0;
        sfr_we   = ~init_cnt[ADDR_W-1];
        sfr_addr = init_cnt[ADDR_W-2:0];
        sfr_wd   = DATA_W'(sfr_start_value(16'(init_cnt[ADDR_W-2:0])));
      end
      ST_ISSUE: begin
        ram_we = lat_write && !is_bit && !dec_sel_sfr;
        sfr_we = lat_write && !is_bit &&  dec_sel_sfr;
      end
      ST_WBACK: begin
        ram_we = !dec_sel_sfr;
        sfr_we =  dec_sel_sfr;
        ram_wd = merge_q;
        sfr_wd = merge_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      init_cnt  <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      lat_mode  <= MODE_DIRECT;
      lat_addr  <= '0;
      lat_write <= 1'b0;
      wdata_q   <= '0;
      merge_q   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (&init_cnt) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            lat_mode  <= req_mode;
            lat_addr  <= req_addr;
            lat_write <= req_write;
            wdata_q   <= req_wdata;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (lat_write && !is_bit) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (is_bit && lat_write) begin
            merge_q <= merged;
            state   <= ST_WBACK;
          end else begin
            rdata <= is_bit ? DATA_W'(fetched[dec_bitpos]) : fetched;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_WBACK: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmau_unit.sv
module dmau_unit #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int BP_W   = $clog2(DATA_W);
  localparam int SFR_AW = ADDR_W - 1;

  logic              dec_sel_sfr;
  logic [ADDR_W-1:0] dec_ram_idx;
  logic [SFR_AW-1:0] dec_sfr_idx;
  logic [BP_W-1:0]   dec_bitpos;
  logic              ram_we, sfr_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [SFR_AW-1:0] sfr_addr;
  logic [DATA_W-1:0] ram_wd, sfr_wd, ram_rd, sfr_rd;
  logic [1:0]        lat_mode;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_write;
  logic              init_active;

  dmau_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_BASE(BIT_BASE)) u_dec (
    .mode    (lat_mode),
    .addr    (lat_addr),
    .sel_sfr (dec_sel_sfr),
    .ram_idx (dec_ram_idx),
    .sfr_idx (dec_sfr_idx),
    .bitpos  (dec_bitpos)
  );

  dmau_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_write   (req_write),
    .dec_sel_sfr (dec_sel_sfr),
    .dec_ram_idx (dec_ram_idx),
    .dec_sfr_idx (dec_sfr_idx),
    .dec_bitpos  (dec_bitpos),
    .ram_rd      (ram_rd),
    .sfr_rd      (sfr_rd),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wd      (ram_wd),
    .sfr_we      (sfr_we),
    .sfr_addr    (sfr_addr),
    .sfr_wd      (sfr_wd),
    .lat_mode    (lat_mode),
    .lat_addr    (lat_addr),
    .lat_write   (lat_write),
    .init_active (init_active),
    .busy        (busy),
    .done        (done),
    .rdata       (rdata)
  );

  dmau_spram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wd   (ram_wd),
    .rd   (ram_rd)
  );

  dmau_spram #(.AW(SFR_AW), .DW(DATA_W)) u_sfr (
    .clk  (clk),
    .we   (sfr_we),
    .addr (sfr_addr),
    .wd   (sfr_wd),
    .rd   (sfr_rd)
  );
endmodule

// File: rtl/dmau_checker.sv
module dmau_checker #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        lat_mode,
  input logic              lat_write,
  input logic              init_active,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              sfr_we,
  input logic [ADDR_W-2:0] sfr_addr
);
  import dmau_pkg::*;

  localparam int BP_W      = $clog2(DATA_W);
  localparam int BIT_BYTES = 1 << (ADDR_W - 1 - BP_W);

  AST_INIT_BUSY: assert property (@(posedge clk) disable iff (rst)
    init_active |-> busy) else $error("init without busy"); // R1

  AST_NO_SFR_INDIRECT: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && !init_active) |-> (lat_mode != MODE_INDIRECT)) else $error("indirect hit sfr"); // R4

  AST_BIT_RAM_REGION: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !init_active && lat_mode == MODE_BIT) |->
      (int'(ram_addr) >= int'(BIT_BASE) && int'(ram_addr) < int'(BIT_BASE) + BIT_BYTES))
    else $error("bit write outside bit area"); // R5

  AST_BIT_SFR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && !init_active && lat_mode == MODE_BIT) |-> (sfr_addr[BP_W-1:0] == '0))
    else $error("unaligned sfr bit byte"); // R6

  AST_BIT_READ_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && lat_mode == MODE_BIT && !lat_write) |-> (rdata[DATA_W-1:1] == '0))
    else $error("bit read wider than one bit"); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy) else $error("accept without busy"); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy"); // R9

  AST_RDATA_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> done) else $error("rdata moved without done"); // R11
endmodule

bind dmau_unit dmau_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_BASE(BIT_BASE)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .busy        (busy),
  .done        (done),
  .rdata       (rdata),
  .lat_mode    (lat_mode),
  .lat_write   (lat_write),
  .init_active (init_active),
  .ram_we      (ram_we),
  .ram_addr    (ram_addr),
  .sfr_we      (sfr_we),
  .sfr_addr    (sfr_addr)
);

// File: tb/dmau_unit_tb_top.sv
module dmau_unit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic       req_write = 1'b0;
  logic       busy, done;
  logic [7:0] rdata;

  dmau_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .busy(busy), .done(done), .rdata(rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] ram_m [256];
  logic [7:0] sfr_m [128];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp,
                       input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d,
                    input logic w, output logic [7:0] r, output int lat);
    while (busy) @(negedge clk);
    req_mode = m; req_addr = a; req_wdata = d; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    r = rdata;
  endtask

  function automatic logic [7:0] direct_model(input logic [7:0] a);
    return a[7] ? sfr_m[a[6:0]] : ram_m[a];
  endfunction

  task automatic model_bit_write(input logic [7:0] a, input logic v);
    if (a[7]) sfr_m[{a[6:3], 3'b000}][a[2:0]] = v;
    else      ram_m[8'h20 + {4'h0, a[6:3]}][a[2:0]] = v;
  endtask

  function automatic logic [7:0] bit_byte_addr(input logic [7:0] a);
    return a[7] ? {a[7:3], 3'b000} : (8'h20 + {4'h0, a[6:3]});
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r, prev;
    int lat;

    for (int i = 0; i < 256; i++) ram_m[i] = 8'h00;
    for (int i = 0; i < 128; i++) sfr_m[i] = 8'h00;
    sfr_m[8'h00] = 8'hFF; sfr_m[8'h10] = 8'hFF; sfr_m[8'h20] = 8'hFF;
    sfr_m[8'h30] = 8'hFF; sfr_m[8'h01] = 8'h07;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {7'd0, busy}, 8'd1, "busy during init");
    check("R1", {7'd0, done}, 8'd0, "done after reset");
    while (busy) @(negedge clk);

    // R1 start values through direct and indirect reads
    for (int a = 0; a < 256; a++) begin
      logic [7:0] exp;
      exp = 8'h00;
      if (a == 8'h80 || a == 8'h90 || a == 8'hA0 || a == 8'hB0) exp = 8'hFF;
      if (a == 8'h81) exp = 8'h07;
      op(2'd0, 8'(a), 8'h00, 1'b0, r, lat);
      check("R1", r, exp, $sformatf("direct start value @%h", a));
    end
    for (int a = 128; a < 256; a++) begin
      op(2'd1, 8'(a), 8'h00, 1'b0, r, lat);
      check("R1", r, 8'h00, $sformatf("upper ram start value @%h", a));
    end

    // R2 R3 direct writes everywhere, R9 byte-write latency
    for (int a = 0; a < 256; a++) begin
      logic [7:0] v;
      v = 8'(a) ^ 8'hA5;
      op(2'd0, 8'(a), v, 1'b1, r, lat);
      if (a[7]) sfr_m[a[6:0]] = v; else ram_m[a] = v;
      if (a == 3) check("R9", 8'(lat), 8'd2, "byte write latency");
    end
    // R4 indirect writes to the upper half
    for (int a = 128; a < 256; a++) begin
      logic [7:0] v;
      v = 8'(a * 3 + 1);
      op(2'd1, 8'(a), v, 1'b1, r, lat);
      ram_m[a] = v;
    end
    // Mode code 3 as direct (R3)
    op(2'd3, 8'h85, 8'h3C, 1'b1, r, lat);
    sfr_m[8'h05] = 8'h3C;
    for (int a = 0; a < 256; a++) begin
      op(2'd0, 8'(a), 8'h00, 1'b0, r, lat);
      check(a[7] ? "R3" : "R2", r, direct_model(8'(a)), $sformatf("direct read @%h", a));
      if (a == 5) check("R9", 8'(lat), 8'd3, "byte read latency");
    end
    for (int a = 0; a < 256; a++) begin
      op(2'd1, 8'(a), 8'h00, 1'b0, r, lat);
      check("R4", r, ram_m[a], $sformatf("indirect read @%h", a));
    end
    op(2'd3, 8'h85, 8'h00, 1'b0, r, lat);
    check("R3", r, 8'h3C, "mode 3 read of 0x85");

    // R5 R6 R7 R8 bit sweep, two passes
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 256; a++) begin
        logic v;
        logic [7:0] ba;
        v = a[0] ^ a[3] ^ p[0];
        op(2'd2, 8'(a), {7'(a ^ 8'h5A), v}, 1'b1, r, lat);
        model_bit_write(8'(a), v);
        if (a == 9) check("R9", 8'(lat), 8'd4, "bit write latency");
        op(2'd2, 8'(a), 8'hFF, 1'b0, r, lat);
        check("R8", r, {7'd0, v}, $sformatf("bit read @%h", a));
        if (a == 9) check("R9", 8'(lat), 8'd3, "bit read latency");
        ba = bit_byte_addr(8'(a));
        op(2'd0, ba, 8'h00, 1'b0, r, lat);
        check(a[7] ? "R6" : "R5", r, direct_model(ba),
              $sformatf("containing byte of bit %h (R7)", a));
      end
    end

    // R10 request during busy is dropped
    while (busy) @(negedge clk);
    req_mode = 2'd2; req_addr = 8'h05; req_wdata = 8'h01; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    check("R9", {7'd0, busy}, 8'd1, "busy after accept");
    req_mode = 2'd0; req_addr = 8'h10; req_wdata = 8'h5A; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    model_bit_write(8'h05, 1'b1);
    op(2'd0, 8'h10, 8'h00, 1'b0, r, lat);
    check("R10", r, ram_m[8'h10], "byte untouched by request during busy");
    op(2'd0, 8'h20, 8'h00, 1'b0, r, lat);
    check("R10", r, ram_m[8'h20], "accepted bit write landed");

    // R11 rdata holds across writes
    op(2'd0, 8'h81, 8'h00, 1'b0, r, lat);
    prev = r;
    op(2'd0, 8'h40, 8'h77, 1'b1, r, lat);
    check("R11", rdata, prev, "rdata after byte write");
    op(2'd2, 8'h91, 8'h01, 1'b1, r, lat);
    check("R11", rdata, prev, "rdata after bit write");

    finish_run();
  end
endmodule